// File: doc/BRIEF.md
# Serial Port Register Block with Receive Queue

This block sits between a processor's 32-bit register bus and the byte-level halves of a serial port. Incoming bytes from a receiver are collected in a small queue, and the processor drains them one at a time by reading a data register. A processor write to the transmit data register is forwarded as a single-cycle byte strobe to a transmitter. Bit shifting, baud timing and any transmit queue live outside this block.

Two watermark counts, one in each control register, set the thresholds for the pending flags. A single level-sensitive interrupt line is computed from the enable register and the queue state. Register accesses complete in the same cycle they are presented. Read data is combinational from the registered state, and a receive-data read that returns a byte removes that byte at the clock edge that ends the access.

Top module: `uart_regif`

## Requirements
- R1: After reset, every register reads zero, the receive queue is empty, `irq` and `tx_valid` are low and `rx_ready` is high.
- R2: A full-width read at offset 0x04 while the queue holds bytes returns the oldest byte in bits 7:0 with all other bits zero, and removes that byte. Bytes come out in arrival order.
- R3: A full-width read at offset 0x04 while the queue is empty returns 0x80000000 and leaves the queue empty.
- R4: The queue holds 8 bytes. `rx_ready` is high exactly while fewer than 8 are held, and a byte presented on `rx_valid` while 8 are held is discarded.
- R5: A push and a pop in the same cycle leave the occupancy unchanged, and the popped byte is the oldest one held before that cycle.
- R6: The pending register at 0x14 has bit 0 set when bits 18:16 of the transmit control register (0x08) are nonzero. It has bit 1 set when the queue occupancy is strictly greater than bits 18:16 of the receive control register (0x0C). All other bits are zero.
- R7: `irq` is high when bit 0 of the enable register (0x10) is set, or when bit 1 of it is set and the queue is non-empty. It is low otherwise.
- R8: A full-width write at offset 0x00 raises `tx_valid` for exactly one cycle, in the cycle after the write, with `tx_byte` equal to write data bits 7:0. A read at 0x00 returns zero.
- R9: The registers at 0x08, 0x0C, 0x10 and 0x18 read back all 32 bits of the last full-width write.
- R10: An access whose byte strobes are not all four set, or whose offset is unaligned or above 0x18, reads zero and changes no state. A partial receive-data read does not remove a byte.
- R11: Writes to the read-only offsets 0x04 and 0x14 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_be | input | 4 | Byte strobes; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Incoming byte present this cycle |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | Queue has room |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_byte | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions watch the queue's invariants on every cycle: the occupancy never goes above the depth, it stays at the depth when a byte arrives while the queue is full, and it does not change on a cycle with both a push and a pop. On every cycle they also check that an empty receive read leaves the queue empty, that each transmit write produces the matching strobe and byte one cycle later, and that the interrupt stays low while both enables are clear. The bench scenarios cover what no single-cycle property can show. These are byte ordering through the queue, full read-back of the control registers, the strict threshold of the receive watermark, rejection of partial and unmapped accesses, and the combined push-and-pop case, each checked against a software model of the queue.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  // word index of each register (byte offset >> 2)
  localparam logic [2:0] IDX_TXDATA = 3'd0;
  localparam logic [2:0] IDX_RXDATA = 3'd1;
  localparam logic [2:0] IDX_TXCTRL = 3'd2;
  localparam logic [2:0] IDX_RXCTRL = 3'd3;
  localparam logic [2:0] IDX_IE     = 3'd4;
  localparam logic [2:0] IDX_IP     = 3'd5;
  localparam logic [2:0] IDX_DIV    = 3'd6;

  // watermark count field inside both control registers
  localparam int WM_LSB = 16;
  localparam int WM_W   = 3;

  // bit positions shared by enable and pending registers
  localparam int BIT_TXWM = 0;
  localparam int BIT_RXWM = 1;

  localparam logic [WORD_W-1:0] RX_EMPTY_WORD = 32'h8000_0000;

  // slots of the plain read/write register bank
  localparam int SLOT_TXCTRL = 0;
  localparam int SLOT_RXCTRL = 1;
  localparam int SLOT_IE     = 2;
  localparam int SLOT_DIV    = 3;
  localparam int NUM_SLOTS   = 4;

endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);

  logic [DEPTH-1:0][DATA_W-1:0] mem_q, mem_d;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign count   = cnt_q;
  assign head_data = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    mem_d    = mem_q;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) begin
      mem_d[wr_ptr_q] = push_data;
      wr_ptr_d        = ptr_inc(wr_ptr_q);
    end
    if (pop_ok) begin
      rd_ptr_d = ptr_inc(rd_ptr_q);
    end
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) begin
        mem_q    <= mem_d;
        wr_ptr_q <= wr_ptr_d;
      end
      if (pop_ok) begin
        rd_ptr_q <= rd_ptr_d;
      end
      if (push_ok != pop_ok) begin
        cnt_q <= cnt_d;
      end
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R4

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == CNT_W'(DEPTH))); // R4

  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_regif_pkg::*;
#(
  parameter int NREG = NUM_SLOTS,
  parameter int W    = WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREG-1:0]         we,
  input  logic [W-1:0]            wdata,
  output logic [NREG-1:0][W-1:0]  q
);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic [W-1:0] slot_q, slot_d;

    always_comb begin
      slot_d = we[g] ? wdata : slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (we[g]) begin
        slot_q <= slot_d;
      end
    end

    assign q[g] = slot_q;
  end

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_regif_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ie,
  input  logic [WORD_W-1:0] txctrl,
  input  logic [WORD_W-1:0] rxctrl,
  input  logic [CNT_W-1:0]  occupancy,
  input  logic              q_empty,
  output logic [WORD_W-1:0] pending,
  output logic              irq
);

  localparam int CMP_W = (CNT_W > WM_W) ? CNT_W : WM_W;

  logic [WM_W-1:0]  tx_mark, rx_mark;
  logic [CMP_W-1:0] occ_ext, rx_mark_ext;
  logic             tx_hit, rx_hit;

  assign tx_mark     = txctrl[WM_LSB +: WM_W];
  assign rx_mark     = rxctrl[WM_LSB +: WM_W];
  assign occ_ext     = CMP_W'(occupancy);
  assign rx_mark_ext = CMP_W'(rx_mark);
  assign tx_hit      = (tx_mark != '0);
  assign rx_hit      = (occ_ext > rx_mark_ext);

  always_comb begin
    pending           = '0;
    pending[BIT_TXWM] = tx_hit;
    pending[BIT_RXWM] = rx_hit;
  end

  assign irq = ie[BIT_TXWM] || (ie[BIT_RXWM] && !q_empty);

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie[BIT_TXWM] && !ie[BIT_RXWM]) |-> !irq); // R7

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              irq
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int IDX_W = ADDR_W - 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // access decode
  logic [IDX_W-1:0] widx;
  logic             acc_ok, wr_acc, rd_acc;
  logic             hit_tx, hit_rx, hit_txc, hit_rxc, hit_ie, hit_ip, hit_div;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign acc_ok  = bus_sel && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  assign wr_acc  = acc_ok && bus_wr;
  assign rd_acc  = acc_ok && !bus_wr;
  assign hit_tx  = (widx == IDX_W'(IDX_TXDATA));
  assign hit_rx  = (widx == IDX_W'(IDX_RXDATA));
  assign hit_txc = (widx == IDX_W'(IDX_TXCTRL));
  assign hit_rxc = (widx == IDX_W'(IDX_RXCTRL));
  assign hit_ie  = (widx == IDX_W'(IDX_IE));
  assign hit_ip  = (widx == IDX_W'(IDX_IP));
  assign hit_div = (widx == IDX_W'(IDX_DIV));

  // plain registers
  logic [NUM_SLOTS-1:0]             slot_we;
  logic [NUM_SLOTS-1:0][WORD_W-1:0] slot_q;

  always_comb begin
    slot_we              = '0;
    slot_we[SLOT_TXCTRL] = wr_acc && hit_txc;
    slot_we[SLOT_RXCTRL] = wr_acc && hit_rxc;
    slot_we[SLOT_IE]     = wr_acc && hit_ie;
    slot_we[SLOT_DIV]    = wr_acc && hit_div;
  end

  uart_ctrl_regs #(
    .NREG (NUM_SLOTS),
    .W    (WORD_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (slot_we),
    .wdata (bus_wdata),
    .q     (slot_q)
  );

  // receive queue
  logic [7:0]       head_byte;
  logic [CNT_W-1:0] occ;
  logic             q_full, q_empty, rx_pop;

  assign rx_pop = rd_acc && hit_rx;

  uart_rx_fifo #(
    .DEPTH  (FIFO_DEPTH),
    .DATA_W (BYTE_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (rx_valid),
    .push_data (rx_byte),
    .pop       (rx_pop),
    .head_data (head_byte),
    .count     (occ),
    .full      (q_full),
    .empty     (q_empty)
  );

  assign rx_ready = !q_full;

  // pending flags and interrupt
  logic [WORD_W-1:0] pend;

  uart_irq_gen #(
    .CNT_W (CNT_W)
  ) u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ie        (slot_q[SLOT_IE]),
    .txctrl    (slot_q[SLOT_TXCTRL]),
    .rxctrl    (slot_q[SLOT_RXCTRL]),
    .occupancy (occ),
    .q_empty   (q_empty),
    .pending   (pend),
    .irq       (irq)
  );

  // outgoing byte strobe
  logic       tx_fire;
  logic       tx_valid_q, tx_valid_d;
  logic [7:0] tx_byte_q, tx_byte_d;

  assign tx_fire = wr_acc && hit_tx;

  always_comb begin
    tx_valid_d = tx_fire;
    tx_byte_d  = tx_fire ? bus_wdata[7:0] : tx_byte_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_valid_q <= 1'b0;
      tx_byte_q  <= '0;
    end else begin
      tx_valid_q <= tx_valid_d;
      if (tx_fire) begin
        tx_byte_q <= tx_byte_d;
      end
    end
  end

  assign tx_valid = tx_valid_q;
  assign tx_byte  = tx_byte_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      unique case (1'b1)
        hit_rx:  bus_rdata = q_empty ? RX_EMPTY_WORD : {24'h0, head_byte};
        hit_txc: bus_rdata = slot_q[SLOT_TXCTRL];
        hit_rxc: bus_rdata = slot_q[SLOT_RXCTRL];
        hit_ie:  bus_rdata = slot_q[SLOT_IE];
        hit_ip:  bus_rdata = pend;
        hit_div: bus_rdata = slot_q[SLOT_DIV];
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_pop && q_empty && !rx_valid) |=> q_empty); // R3

  AST_TX_BYTE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_fire |=> (tx_valid && tx_byte == $past(bus_wdata[7:0]))); // R8

  AST_NO_SPURIOUS_TX: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_fire |=> !tx_valid); // R8

endmodule

// File: tb/uart_regif_tb_top.sv
module uart_regif_tb_top;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_byte;

  always #10 clk = ~clk;

  uart_regif dut_i (
    .clk (clk), .rst_n (rst_n),
    .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_be (bus_be), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .rx_valid (rx_valid), .rx_byte (rx_byte), .rx_ready (rx_ready),
    .tx_valid (tx_valid), .tx_byte (tx_byte), .irq (irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [7:0]  tx_exp_q[$];
  logic [7:0]  model_q[$];
  logic [31:0] m_txctrl = '0, m_rxctrl = '0, m_ie = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ip();
    logic [31:0] v = '0;
    v[0] = (m_txctrl[18:16] != 3'd0);
    v[1] = (model_q.size() > int'(m_rxctrl[18:16]));
    return v;
  endfunction

  function automatic logic exp_irq();
    return m_ie[0] || (m_ie[1] && model_q.size() != 0);
  endfunction

  // monitor: register reads
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    if (rst_n && bus_sel && !bus_wr) begin
      if (rd_exp_q.size() == 0) begin
        chk(1'b0, "SB read underflow", bus_rdata, '0);
      end else begin
        e = rd_exp_q.pop_front();
        t = rd_tag_q.pop_front();
        chk(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  // monitor: outgoing bytes (R8)
  always @(negedge clk) begin
    logic [7:0] b;
    if (rst_n && tx_valid) begin
      if (tx_exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected tx_valid", {24'h0, tx_byte}, '0);
      end else begin
        b = tx_exp_q.pop_front();
        chk(tx_byte === b, "R8 tx_byte", {24'h0, tx_byte}, {24'h0, b});
      end
    end
  end

  // drivers: each starts and ends 2 ns after a rising edge
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d,
                           input logic [3:0] be = 4'hF);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    if (be == 4'hF) begin
      case (a)
        5'h00: tx_exp_q.push_back(d[7:0]);
        5'h08: m_txctrl = d;
        5'h0C: m_rxctrl = d;
        5'h10: m_ie = d;
        default: ;
      endcase
    end
    @(posedge clk); #2;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic [31:0] exp,
                          input string tag, input logic [3:0] be = 4'hF);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
    @(posedge clk); #2;
    bus_sel = 1'b0;
  endtask

  task automatic read_rx(input string tag);
    logic [31:0] e;
    if (model_q.size() != 0) e = {24'h0, model_q.pop_front()};
    else e = 32'h8000_0000;
    bus_read(5'h04, e, tag);
  endtask

  task automatic rx_push(input logic [7:0] b, input string tag);
    chk(rx_ready === (model_q.size() < DEPTH), tag, {31'h0, rx_ready},
        {31'h0, model_q.size() < DEPTH});
    rx_valid = 1'b1; rx_byte = b;
    if (model_q.size() < DEPTH) model_q.push_back(b);
    @(posedge clk); #2;
    rx_valid = 1'b0;
  endtask

  task automatic push_and_read(input logic [7:0] b, input string tag);
    logic [31:0] e;
    e = {24'h0, model_q.pop_front()};
    rd_exp_q.push_back(e);
    rd_tag_q.push_back(tag);
    model_q.push_back(b);
    rx_valid = 1'b1; rx_byte = b;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h04; bus_be = 4'hF;
    @(posedge clk); #2;
    bus_sel = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic check_irq(input string tag);
    chk(irq === exp_irq(), tag, {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WATCHDOG expired", '0, '0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;

    // R1: reset state
    chk(irq === 1'b0, "R1 irq", {31'h0, irq}, 0);
    chk(rx_ready === 1'b1, "R1 rx_ready", {31'h0, rx_ready}, 1);
    chk(tx_valid === 1'b0, "R1 tx_valid", {31'h0, tx_valid}, 0);
    bus_read(5'h08, 0, "R1 txctrl");
    bus_read(5'h0C, 0, "R1 rxctrl");
    bus_read(5'h10, 0, "R1 ie");
    bus_read(5'h14, 0, "R1 ip");
    bus_read(5'h18, 0, "R1 div");
    // R3: empty read, twice, still empty
    read_rx("R3 empty read");
    read_rx("R3 empty read again");

    // R9: read-back
    bus_write(5'h08, 32'hDEAD_BEEF);
    bus_write(5'h0C, 32'h0A5A_C3C3);
    bus_write(5'h10, 32'hFFFF_FFFC);
    bus_write(5'h18, 32'h1234_5678);
    bus_read(5'h08, 32'hDEAD_BEEF, "R9 txctrl");
    bus_read(5'h0C, 32'h0A5A_C3C3, "R9 rxctrl");
    bus_read(5'h10, 32'hFFFF_FFFC, "R9 ie");
    bus_read(5'h18, 32'h1234_5678, "R9 div");
    check_irq("R7 upper enable bits only");

    // R6: transmit watermark
    bus_read(5'h14, exp_ip(), "R6 ip tx mark nonzero");
    bus_write(5'h08, 32'hFFF8_FFFF);
    bus_read(5'h14, exp_ip(), "R6 ip tx mark zero");
    bus_write(5'h08, 32'h0001_0000);
    bus_read(5'h14, exp_ip(), "R6 ip tx mark one");
    bus_write(5'h08, 0);
    bus_write(5'h10, 0);

    // R6: receive watermark is strict
    rx_push(8'h11, "R4 ready");
    rx_push(8'h22, "R4 ready");
    rx_push(8'h33, "R4 ready");
    bus_write(5'h0C, 32'h0002_0000);
    bus_read(5'h14, exp_ip(), "R6 ip occ3 > mark2");
    bus_write(5'h0C, 32'h0003_0000);
    bus_read(5'h14, exp_ip(), "R6 ip occ3 == mark3");

    // R7: interrupt line
    bus_write(5'h10, 32'h2);
    check_irq("R7 rx enable nonempty");
    read_rx("R2 oldest byte");
    read_rx("R2 second byte");
    check_irq("R7 rx enable one left");
    read_rx("R2 third byte");
    check_irq("R7 rx enable empty");
    bus_write(5'h10, 32'h1);
    check_irq("R7 tx enable");
    bus_write(5'h10, 0);
    check_irq("R7 both clear");

    // R4: fill past depth
    for (int i = 0; i < 10; i++) rx_push(8'hA0 + 8'(i), "R4 ready vs occupancy");
    for (int i = 0; i < 8; i++) read_rx("R4 order after overflow");
    read_rx("R4 R3 drained to empty");
    chk(rx_ready === 1'b1, "R4 ready after drain", {31'h0, rx_ready}, 1);

    // R5: push and pop together
    rx_push(8'h5A, "R5 setup");
    rx_push(8'h6B, "R5 setup");
    push_and_read(8'h7C, "R5 pop during push");
    bus_write(5'h0C, 32'h0001_0000);
    bus_read(5'h14, exp_ip(), "R5 occupancy still 2 (above 1)");
    bus_write(5'h0C, 32'h0002_0000);
    bus_read(5'h14, exp_ip(), "R5 occupancy still 2 (not above 2)");
    read_rx("R5 next byte");
    read_rx("R5 pushed byte");
    bus_write(5'h0C, 0);

    // R8: outgoing bytes
    bus_write(5'h00, 32'h1234_56A5);
    bus_write(5'h00, 32'h0000_003C);
    bus_write(5'h00, 32'hFFFF_FF00);
    bus_read(5'h00, 0, "R8 txdata reads zero");
    repeat (2) @(posedge clk);
    #2;
    chk(tx_exp_q.size() == 0, "R8 all bytes sent", tx_exp_q.size(), 0);

    // R10: partial, unaligned and unmapped accesses
    bus_write(5'h10, 32'h3, 4'h3);
    check_irq("R10 partial ie write ignored");
    bus_read(5'h10, 0, "R10 ie unchanged");
    bus_write(5'h00, 32'h77, 4'h1);
    rx_push(8'h99, "R10 setup");
    bus_read(5'h04, 0, "R10 partial rx read zero", 4'h3);
    bus_read(5'h05, 0, "R10 unaligned read zero");
    bus_write(5'h1C, 32'hFFFF_FFFF);
    bus_read(5'h1C, 0, "R10 unmapped read zero");
    bus_write(5'h19, 32'hFFFF_FFFF);
    bus_read(5'h18, 32'h1234_5678, "R10 unaligned write ignored");
    read_rx("R10 byte kept after partial read");

    // R11: read-only offsets
    bus_write(5'h04, 32'h0000_00EE);
    read_rx("R11 rxdata write ignored");
    bus_write(5'h14, 32'hFFFF_FFFF);
    bus_read(5'h14, exp_ip(), "R11 ip write ignored");
    check_irq("R11 irq unchanged");

    repeat (3) @(posedge clk);
    #2;
    chk(rd_exp_q.size() == 0, "SB reads drained", rd_exp_q.size(), 0);
    chk(tx_exp_q.size() == 0, "R8 no stray byte", tx_exp_q.size(), 0);
    finish_run();
  end

endmodule